// File: doc/BRIEF.md
# UART Banked Register Decoder

This block sits between a host register bus and the configuration state of a UART. A 3-bit offset selects one of eight register slots. What those slots reach depends on the value held in the line control register, so three register sets share the same small address window.

The three sets are the general set, the divisor-latch set and the enhanced-feature set. The divisor-latch set holds the low and high divisor bytes and a fractional divisor register. That fractional register also chooses 16x, 8x or 4x oversampling. Accesses to the general set are passed straight through to a companion serial engine, which owns the holding registers, interrupt enable and interrupt status. The divisor, fractional, feature and line control values are exported as ports for a baud generator.

A small state machine tracks the selected bank. It has three states:

- **BANK_GEN** (general set). This is the reset state.
- **BANK_DIV** (divisor-latch set).
- **BANK_ENH** (enhanced-feature set).

Only a write to offset 3 moves it, and the new state depends on the byte written:

- **to_enh**: the byte is exactly 0xBF, so the next state is BANK_ENH.
- **to_div**: bit 7 is 1 and the byte is not 0xBF, so the next state is BANK_DIV.
- **to_gen**: bit 7 is 0, so the next state is BANK_GEN.

Writing a byte that maps to the current state keeps that state (**hold**). A state's output process produces one select line per register.

Top module: `ubank_top`

## Requirements
- R1: After reset, line control, both divisor bytes, the fractional register and the feature register read as 0, and the bank is the general set.
- R2: While line control has bit 7 set and is not 0xBF, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. `div_value` equals {high, low}.
- R3: In that same divisor bank, offset 2 reaches the fractional register. Written bits 3:0 set `frac_value`, bit 4 selects 8x and bit 5 selects 4x. `sample_mode` is 0 for 16x, 1 for 8x and 2 for 4x. A read returns {2'b00, bit5, bit4, bits 3:0}.
- R4: A fractional write with bits 5 and 4 both 1 stores its bits 3:0 and stores the mode bits as 0 (16x).
- R5: While line control equals exactly 0xBF, offset 2 reads and writes the feature register, and the fractional register is left unchanged.
- R6: Offset 3 reads and writes line control in every bank. A write takes effect on the next clock edge, and the bank follows it from the next cycle.
- R7: While line control bit 7 is 0, accesses to offsets 0 to 2 raise `gen_we` or `gen_re` in the same cycle, with `gen_addr` equal to the offset and `gen_wdata` equal to the bus data. A read returns `gen_rdata`. These accesses leave the divisor, fractional and feature registers unchanged.
- R8: Back-to-back reads of offset 0 in the general bank each raise `gen_re` with `gen_addr` 0. The address never advances.
- R9: An offset that is unmapped in the current bank ignores writes and reads as 0. Unmapped means offsets 4 to 7 in every bank, and offsets 0 and 1 in the enhanced bank. `gen_we` and `gen_re` stay low outside the general bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data; 0 when `bus_re` is low |
| gen_we | output | 1 | Write forwarded to the general set |
| gen_re | output | 1 | Read forwarded to the general set (pops the receive entry at offset 0) |
| gen_addr | output | 2 | Offset of the forwarded access |
| gen_wdata | output | 8 | Data of the forwarded write |
| gen_rdata | input | 8 | Read data returned by the general set |
| div_value | output | 16 | Integer divisor {high, low} |
| frac_value | output | 4 | Fractional divisor |
| sample_mode | output | 2 | Oversampling: 0 is 16x, 1 is 8x, 2 is 4x |
| feat_value | output | 8 | Enhanced feature register |
| line_ctrl | output | 8 | Line control register |

## Verification
A read and a write can land in the same cycle. The case that matters is both strobes raised at offset 3 while line control is rewritten, which switches bank. The bench does exactly that: it writes 0xBF from the divisor bank with `bus_re` held high. It expects the read to return the old line control value, with the enhanced bank visible only in the following cycle. The behavioural model compares every output against the same ordering on every clock, so an early bank switch or a stale select line is reported.

// File: rtl/ubank_pkg.sv
package ubank_pkg;

    typedef enum logic [1:0] {
        BANK_GEN = 2'd0,
        BANK_DIV = 2'd1,
        BANK_ENH = 2'd2
    } bank_e;

    typedef struct packed {
        logic lcr;
        logic gen;
        logic dll;
        logic dlh;
        logic frac;
        logic efr;
    } hit_t;

endpackage

// File: rtl/ubank_fsm.sv
module ubank_fsm
    import ubank_pkg::*;
#(
    parameter int               ADDR_W    = 3,
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] MAGIC_LCR = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output bank_e             bank,
    output hit_t              hit
);
    localparam logic [ADDR_W-1:0] OFF_0   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_1   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_2   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_LCR = ADDR_W'(3);

    bank_e state, next_state, target;
    logic  lcr_wr;

    assign lcr_wr = we && (addr == OFF_LCR);
    assign bank   = state;

    always_comb begin
        if (wdata == MAGIC_LCR)        target = BANK_ENH;
        else if (wdata[DATA_W-1])      target = BANK_DIV;
        else                           target = BANK_GEN;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BANK_GEN;
        else        state <= next_state;
    end

    // transitions: to_enh, to_div, to_gen, hold
    always_comb begin
        next_state = state;
        unique case (state)
            BANK_GEN: if (lcr_wr && target != BANK_GEN) next_state = target;
            BANK_DIV: if (lcr_wr && target != BANK_DIV) next_state = target;
            BANK_ENH: if (lcr_wr && target != BANK_ENH) next_state = target;
            default:  next_state = BANK_GEN;
        endcase
    end

    // outputs: one select per register
    always_comb begin
        hit     = '0;
        hit.lcr = (addr == OFF_LCR);
        unique case (state)
            BANK_GEN: hit.gen = (addr < OFF_LCR);
            BANK_DIV: begin
                hit.dll  = (addr == OFF_0);
                hit.dlh  = (addr == OFF_1);
                hit.frac = (addr == OFF_2);
            end
            BANK_ENH: hit.efr = (addr == OFF_2);
            default:  hit     = '0;
        endcase
    end
endmodule

// File: rtl/ubank_regs.sv
module ubank_regs
    import ubank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    input  hit_t                hit,
    output logic [DATA_W-1:0]   lcr,
    output logic [DATA_W-1:0]   dll,
    output logic [DATA_W-1:0]   dlh,
    output logic [FRAC_W+1:0]   frac_reg,
    output logic [DATA_W-1:0]   efr
);
    logic [1:0] mode_in;

    // an illegal pair of mode bits falls back to 16x
    assign mode_in = (&wdata[FRAC_W+1:FRAC_W]) ? 2'b00 : wdata[FRAC_W+1:FRAC_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr      <= '0;
            dll      <= '0;
            dlh      <= '0;
            frac_reg <= '0;
            efr      <= '0;
        end else if (we) begin
            if (hit.lcr)  lcr      <= wdata;
            if (hit.dll)  dll      <= wdata;
            if (hit.dlh)  dlh      <= wdata;
            if (hit.frac) frac_reg <= {mode_in, wdata[FRAC_W-1:0]};
            if (hit.efr)  efr      <= wdata;
        end
    end
endmodule

// File: rtl/ubank_top.sv
module ubank_top
    import ubank_pkg::*;
#(
    parameter int                ADDR_W    = 3,
    parameter int                DATA_W    = 8,
    parameter int                FRAC_W    = 4,
    parameter logic [DATA_W-1:0] MAGIC_LCR = 8'hBF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  gen_we,
    output logic                  gen_re,
    output logic [1:0]            gen_addr,
    output logic [DATA_W-1:0]     gen_wdata,
    input  logic [DATA_W-1:0]     gen_rdata,
    output logic [2*DATA_W-1:0]   div_value,
    output logic [FRAC_W-1:0]     frac_value,
    output logic [1:0]            sample_mode,
    output logic [DATA_W-1:0]     feat_value,
    output logic [DATA_W-1:0]     line_ctrl
);
    localparam int PAD_W = DATA_W - FRAC_W - 2;

    bank_e               bank;
    hit_t                hit;
    logic [DATA_W-1:0]   lcr, dll, dlh, efr;
    logic [FRAC_W+1:0]   frac_reg;

    ubank_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAGIC_LCR(MAGIC_LCR)) i_fsm (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .bank(bank), .hit(hit)
    );

    ubank_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .wdata(bus_wdata), .hit(hit),
        .lcr(lcr), .dll(dll), .dlh(dlh), .frac_reg(frac_reg), .efr(efr)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (hit.lcr)       bus_rdata = lcr;
            else if (hit.gen)  bus_rdata = gen_rdata;
            else if (hit.dll)  bus_rdata = dll;
            else if (hit.dlh)  bus_rdata = dlh;
            else if (hit.frac) bus_rdata = {{PAD_W{1'b0}}, frac_reg};
            else if (hit.efr)  bus_rdata = efr;
        end
    end

    assign gen_we      = bus_we && hit.gen;
    assign gen_re      = bus_re && hit.gen;
    assign gen_addr    = bus_addr[1:0];
    assign gen_wdata   = bus_wdata;
    assign div_value   = {dlh, dll};
    assign frac_value  = frac_reg[FRAC_W-1:0];
    assign sample_mode = frac_reg[FRAC_W+1:FRAC_W];
    assign feat_value  = efr;
    assign line_ctrl   = lcr;
endmodule

// File: rtl/ubank_chk.sv
module ubank_chk
    import ubank_pkg::*;
#(
    parameter int                ADDR_W    = 3,
    parameter int                DATA_W    = 8,
    parameter int                FRAC_W    = 4,
    parameter logic [DATA_W-1:0] MAGIC_LCR = 8'hBF
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                gen_we,
    input logic                gen_re,
    input logic [2*DATA_W-1:0] div_value,
    input logic [FRAC_W-1:0]   frac_value,
    input logic [1:0]          sample_mode,
    input logic [DATA_W-1:0]   line_ctrl,
    input bank_e               bank
);
    // R7
    gen_only_in_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we || gen_re) |-> !line_ctrl[DATA_W-1]);

    // R4
    no_dual_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_mode != 2'b11);

    // R5
    frac_held_in_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ctrl == MAGIC_LCR) |=> ($stable(frac_value) && $stable(sample_mode)));

    // R2
    div_held_in_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ctrl[DATA_W-1] |=> $stable(div_value));

    // R6
    lcr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(3)) |=> (line_ctrl == $past(bus_wdata)));

    // R6
    bank_tracks_lcr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ctrl == MAGIC_LCR) == (bank == BANK_ENH));

    // R9
    high_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr >= ADDR_W'(4)) |-> (bus_rdata == '0));
endmodule

bind ubank_top ubank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .MAGIC_LCR(MAGIC_LCR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .gen_we(gen_we), .gen_re(gen_re), .div_value(div_value),
    .frac_value(frac_value), .sample_mode(sample_mode),
    .line_ctrl(line_ctrl), .bank(bank)
);

// File: tb/test_ubank_top.sv
module test_ubank_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        gen_we, gen_re;
    logic [1:0]  gen_addr;
    logic [7:0]  gen_wdata;
    logic [7:0]  gen_rdata = '0;
    logic [15:0] div_value;
    logic [3:0]  frac_value;
    logic [1:0]  sample_mode;
    logic [7:0]  feat_value;
    logic [7:0]  line_ctrl;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_lcr, m_dll, m_dlh, m_frac, m_mode, m_efr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ubank_top i_ubank_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .gen_we(gen_we), .gen_re(gen_re), .gen_addr(gen_addr),
        .gen_wdata(gen_wdata), .gen_rdata(gen_rdata), .div_value(div_value),
        .frac_value(frac_value), .sample_mode(sample_mode),
        .feat_value(feat_value), .line_ctrl(line_ctrl)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // 0 general, 1 divisor, 2 enhanced
    function automatic int m_bank();
        if (m_lcr == 8'hBF) return 2;
        if (m_lcr >= 8'h80) return 1;
        return 0;
    endfunction

    task automatic compare_all(input string tag, input bit we, input bit re,
                               input int a, input int d);
        int bk = m_bank();
        int exp_rd = 0;
        bit fwd = (bk == 0) && (a < 3);
        if (re) begin
            if (a == 3)                 exp_rd = m_lcr;
            else if (fwd)               exp_rd = gen_rdata;
            else if (bk == 1 && a == 0) exp_rd = m_dll;
            else if (bk == 1 && a == 1) exp_rd = m_dlh;
            else if (bk == 1 && a == 2) exp_rd = (m_mode << 4) | m_frac;
            else if (bk == 2 && a == 2) exp_rd = m_efr;
        end
        chk(tag, "rdata", bus_rdata, exp_rd);
        chk(tag, "gen_we", gen_we, we && fwd);
        chk(tag, "gen_re", gen_re, re && fwd);
        if (fwd) chk(tag, "gen_addr", gen_addr, a);
        if (fwd && we) chk(tag, "gen_wdata", gen_wdata, d);
        chk(tag, "div_value", div_value, (m_dlh << 8) | m_dll);
        chk(tag, "frac_value", frac_value, m_frac);
        chk(tag, "sample_mode", sample_mode, m_mode);
        chk(tag, "feat_value", feat_value, m_efr);
        chk(tag, "line_ctrl", line_ctrl, m_lcr);
    endtask

    task automatic model_write(input int a, input int d);
        int bk = m_bank();
        if (a == 3) m_lcr = d;
        else if (bk == 1 && a == 0) m_dll = d;
        else if (bk == 1 && a == 1) m_dlh = d;
        else if (bk == 1 && a == 2) begin
            m_frac = d & 4'hF;
            m_mode = ((d >> 4) & 3) == 3 ? 0 : (d >> 4) & 3;
        end
        else if (bk == 2 && a == 2) m_efr = d;
    endtask

    task automatic op(input string tag, input bit we, input bit re,
                      input int a, input int d);
        @(posedge clk);
        #1;
        bus_we    = we;
        bus_re    = re;
        bus_addr  = a[2:0];
        bus_wdata = d[7:0];
        gen_rdata = 8'hA0 + 8'(a);
        @(negedge clk);
        compare_all(tag, we, re, a, d);
        if (we) model_write(a, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_lcr = 0; m_dll = 0; m_dlh = 0; m_frac = 0; m_mode = 0; m_efr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        op("R1", 0, 1, 3, 0);
        op("R1", 0, 0, 0, 0);

        // R7 general bank forwarding
        op("R7", 1, 0, 0, 8'h11);
        op("R7", 0, 1, 1, 0);
        op("R7", 1, 1, 2, 8'h22);
        // R8 repeated reads at offset 0 stay at offset 0
        op("R8", 0, 1, 0, 0);
        op("R8", 0, 1, 0, 0);
        op("R8", 0, 1, 0, 0);
        // R9 unmapped offsets in general bank
        op("R9", 1, 0, 5, 8'hEE);
        op("R9", 0, 1, 5, 0);
        op("R9", 0, 1, 7, 0);

        // R6 enter divisor bank
        op("R6", 1, 0, 3, 8'h80);
        op("R6", 0, 1, 3, 0);
        // R2 divisor latches
        op("R2", 1, 0, 0, 8'h34);
        op("R2", 1, 0, 1, 8'h12);
        op("R2", 0, 1, 0, 0);
        op("R2", 0, 1, 1, 0);
        // R3 fractional register and sampling modes
        op("R3", 1, 0, 2, 8'h17);
        op("R3", 0, 1, 2, 0);
        op("R3", 1, 0, 2, 8'h2A);
        op("R3", 0, 1, 2, 0);
        op("R3", 1, 0, 2, 8'hC5);
        op("R3", 0, 1, 2, 0);
        // R4 both mode bits set
        op("R4", 1, 0, 2, 8'h3F);
        op("R4", 0, 1, 2, 0);
        op("R3", 1, 0, 2, 8'h19);
        // R9 unmapped in divisor bank
        op("R9", 1, 0, 6, 8'h77);
        op("R9", 0, 1, 6, 0);

        // R6 same-cycle read and bank-changing write of line control
        op("R6", 1, 1, 3, 8'hBF);
        op("R6", 0, 1, 3, 0);
        // R5 enhanced bank
        op("R5", 1, 0, 2, 8'h55);
        op("R5", 0, 1, 2, 0);
        op("R5", 0, 0, 0, 0);
        // R9 offsets 0 and 1 unmapped in enhanced bank
        op("R9", 1, 0, 0, 8'h99);
        op("R9", 1, 0, 1, 8'h98);
        op("R9", 0, 1, 0, 0);
        op("R9", 0, 1, 1, 0);

        // R6 divisor bank again, fractional retained
        op("R6", 1, 0, 3, 8'h83);
        op("R5", 0, 1, 2, 0);
        op("R2", 0, 1, 0, 0);

        // R7 back to general bank, divisor untouched by general writes
        op("R6", 1, 0, 3, 8'h03);
        op("R7", 1, 0, 1, 8'h77);
        op("R7", 1, 0, 0, 8'h66);
        op("R7", 0, 1, 2, 0);
        op("R8", 0, 1, 0, 0);

        // R1 mid-run reset
        @(posedge clk);
        #1 rst_n = 1'b0;
        bus_we = 1'b0;
        bus_re = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        m_lcr = 0; m_dll = 0; m_dlh = 0; m_frac = 0; m_mode = 0; m_efr = 0;
        op("R1", 0, 1, 3, 0);
        op("R1", 0, 1, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule